// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a physical memory address for a 16-bit segmented memory model. It holds four segment bases: extra, code, stack and data. For each access it picks one of them, either from the kind of access or from an explicit override, and adds the offset to the base shifted left by four bits.

The sum can carry into a twenty-first bit. A gate input decides how that carry is handled. When the gate is open, the carry reaches the output, so the first 64 KB above the 1 MB line, less sixteen bytes, can be addressed. When the gate is closed, bit 20 is forced low, the address folds back to the bottom of memory, and a wrap indication is raised.

The four segment bases are loaded through a simple synchronous write port. The address path holds no registers, so a new offset, access kind or override shows up at the output in the same cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: With the gate open, `phys_addr` equals the selected base times 16 plus `offset`, as a 21-bit value. It changes in the same cycle as `offset`, `acc_kind` or `ovr_sel` change.
- R2: With no override, `acc_kind` picks the base: 0 (data) uses the data base, 1 (stack) uses the stack base, 2 (fetch) uses the code base, and 3 is handled as data.
- R3: If `ovr_sel` bit 2 is set, the override wins over the default: 4 selects extra, 5 code, 6 stack and 7 data. The values 0 to 3 mean no override.
- R4: With the gate closed, bit 20 of `phys_addr` is 0 and bits 19:0 equal bits 19:0 of the sum.
- R5: `wrap_flag` is 1 exactly when the gate is closed and the sum has bit 20 set. Otherwise it is 0.
- R6: With the gate open, base 0xFFFF and offset 0xFFFF give 0x10FFEF, the highest reachable address. With the gate closed, the same inputs give 0x0FFEF with `wrap_flag` set.
- R7: A write with `wr_en` high stores `wr_data` into the base chosen by `wr_sel` (0 extra, 1 code, 2 stack, 3 data) at the next rising edge. The other bases keep their values.
- R8: While `rst_n` is low, all four bases clear to zero at each rising edge and `wr_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment base write strobe |
| wr_sel | input | 2 | Base to write: 0 extra, 1 code, 2 stack, 3 data |
| wr_data | input | 16 | Value to write |
| acc_kind | input | 2 | 0 data, 1 stack, 2 fetch, 3 data |
| ovr_sel | input | 3 | 0-3 none, 4 extra, 5 code, 6 stack, 7 data |
| offset | input | 16 | Offset within the segment |
| a20_en | input | 1 | High lets the carry into bit 20 through |
| phys_addr | output | 21 | Physical address |
| wrap_flag | output | 1 | Set when a carry into bit 20 was dropped |

## Verification
The assertions assume that every input is driven to a known value in each cycle after reset. They also assume that writes arrive only through the write port, so a base changes only on an edge where `wr_en` is high. The bench drives all inputs away from the rising edge and keeps them at defined values from time zero. It draws random values for every field, including the reserved access kind and the unused override codes. Directed cases add all-ones bases and offsets, with the gate both open and closed.

// File: rtl/sag_pkg.sv
// Shared definitions for the segmented address generator.
// Assumes four segment bases, indexed in the order the override code uses.
package sag_pkg;
    localparam int NSEG = 4;
    localparam int SEG_IDX_W = $clog2(NSEG);

    // Base index: the override code's low two bits map directly onto it.
    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_idx_t;

    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_STACK = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/sag_seg_file.sv
// Segment base storage: one register per base, each with its own write decode.
// Assumes a synchronous active-low reset that also masks the write port.
module sag_seg_file #(
    parameter int SEG_W = 16,
    parameter int NSEG  = sag_pkg::NSEG
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NSEG)-1:0]     wr_sel,
    input  logic [SEG_W-1:0]            wr_data,
    output logic [NSEG-1:0][SEG_W-1:0]  seg_o
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Holds one base; clears in reset, loads when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_o[g] <= '0;
            else if (wr_en && (wr_sel == g))
                seg_o[g] <= wr_data;
        end

        // R8: the first cycle out of reset sees a cleared base.
        a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (seg_o[g] == '0));
    end

    // R7: the written value is present one edge after the strobe.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(rst_n)) |=> (seg_o[$past(wr_sel)] == $past(wr_data)));

    // R7: with no strobe, every base holds its value.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(seg_o));
endmodule

// File: rtl/sag_seg_pick.sv
// Base selection: an explicit override wins, otherwise the access kind picks.
// Assumes override codes below 4 mean "none". The output is a one-hot grant.
module sag_seg_pick #(
    parameter int NSEG = sag_pkg::NSEG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      acc_kind,
    input  logic [2:0]      ovr_sel,
    output logic [NSEG-1:0] sel_oh
);
    import sag_pkg::*;

    seg_idx_t dflt_idx;
    seg_idx_t pick_idx;

    // Maps the access kind to its default base.
    always_comb begin
        case (acc_kind_t'(acc_kind))
            ACC_STACK: dflt_idx = SEG_STACK;
            ACC_FETCH: dflt_idx = SEG_CODE;
            default:   dflt_idx = SEG_DATA;
        endcase
    end

    // Applies the override when its enable bit is set.
    always_comb begin
        pick_idx = ovr_sel[2] ? seg_idx_t'(ovr_sel[1:0]) : dflt_idx;
    end

    // Expands the chosen index into a one-hot grant.
    always_comb begin
        sel_oh = '0;
        sel_oh[pick_idx] = 1'b1;
    end

    // R2 R3: exactly one base is granted per access.
    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_oh) == 1);

    // R2: a stack access without an override never takes the code or extra base.
    a_r2_stack_default: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_sel[2] && acc_kind == 2'd1) |-> sel_oh[SEG_STACK]);
endmodule

// File: rtl/sag_addr_calc.sv
// Address arithmetic: muxes the granted base, shifts it and adds the offset,
// then applies the bit-20 gate. Purely combinational; clk is for checks only.
module sag_addr_calc #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int NSEG   = sag_pkg::NSEG,
    parameter int ADDR_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSEG-1:0][SEG_W-1:0]  seg_i,
    input  logic [NSEG-1:0]             sel_oh,
    input  logic [OFF_W-1:0]            offset,
    input  logic                        a20_en,
    output logic [ADDR_W-1:0]           phys_addr,
    output logic                        wrap_flag
);
    localparam int BASE_W = SEG_W + SHIFT;
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(1) << OFF_W;
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'({SEG_W{1'b1}}) * ADDR_W'(1 << SHIFT)
                                      + ADDR_W'({OFF_W{1'b1}});

    logic [NSEG-1:0][SEG_W-1:0] masked;
    logic [SEG_W-1:0]           seg_sel;
    logic [ADDR_W-1:0]          base;
    logic [ADDR_W-1:0]          raw;

    // Gates each base by its grant bit.
    for (genvar g = 0; g < NSEG; g++) begin : g_mask
        assign masked[g] = sel_oh[g] ? seg_i[g] : '0;
    end

    // ORs the gated bases into the selected one.
    always_comb begin
        seg_sel = '0;
        for (int i = 0; i < NSEG; i++) seg_sel = seg_sel | masked[i];
    end

    // Forms the full-width sum of the shifted base and the offset.
    always_comb begin
        base = ADDR_W'({seg_sel, {SHIFT{1'b0}}});
        raw  = base + ADDR_W'(offset);
    end

    // Drops the top carry when the gate is closed and reports it.
    always_comb begin
        phys_addr = raw;
        wrap_flag = 1'b0;
        if (!a20_en) begin
            phys_addr[ADDR_W-1] = 1'b0;
            wrap_flag = raw[ADDR_W-1];
        end
    end

    // R4: a closed gate never lets bit 20 out.
    a_r4_top_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_en |-> !phys_addr[ADDR_W-1]);

    // R5: a wrap is only reported with the gate closed.
    a_r5_wrap_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_flag |-> !a20_en);

    // R1: with the gate open the address lies inside the base's 64 KB window.
    a_r1_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        a20_en |-> ((phys_addr >= base) && ((phys_addr - base) < WIN)));

    // R6: the open-gate address never passes the highest reachable value.
    a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        a20_en |-> (phys_addr <= TOP));
endmodule

// File: rtl/seg_addr_gen.sv
// Top level: segment base storage, base selection and address arithmetic.
// Assumes inputs are stable around the rising edge. The address path has no state.
module seg_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic [1:0]        acc_kind,
    input  logic [2:0]        ovr_sel,
    input  logic [OFF_W-1:0]  offset,
    input  logic              a20_en,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              wrap_flag
);
    import sag_pkg::*;

    logic [NSEG-1:0][SEG_W-1:0] seg_q;
    logic [NSEG-1:0]            sel_oh;

    sag_seg_file #(.SEG_W(SEG_W), .NSEG(NSEG)) i_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .seg_o   (seg_q)
    );

    sag_seg_pick #(.NSEG(NSEG)) i_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_kind (acc_kind),
        .ovr_sel  (ovr_sel),
        .sel_oh   (sel_oh)
    );

    sag_addr_calc #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .NSEG(NSEG), .ADDR_W(ADDR_W)
    ) i_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_i     (seg_q),
        .sel_oh    (sel_oh),
        .offset    (offset),
        .a20_en    (a20_en),
        .phys_addr (phys_addr),
        .wrap_flag (wrap_flag)
    );
endmodule

// File: tb/test_seg_addr_gen.sv
// Self-checking bench: directed corners plus seeded random traffic against a model.
module test_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  ovr_sel = '0;
    logic [15:0] offset = '0;
    logic        a20_en = 1'b1;
    logic [20:0] phys_addr;
    logic        wrap_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mseg [4];

    always #4 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_kind(acc_kind), .ovr_sel(ovr_sel), .offset(offset), .a20_en(a20_en),
        .phys_addr(phys_addr), .wrap_flag(wrap_flag)
    );

    // Index of the base the requirements pick (R2, R3).
    function automatic int pick(input logic [1:0] k, input logic [2:0] o);
        if (o[2]) return int'(o[1:0]);
        case (k)
            2'd1: return 2;
            2'd2: return 1;
            default: return 3;
        endcase
    endfunction

    function automatic logic [20:0] raw_sum(input logic [15:0] s, input logic [15:0] f);
        return {1'b0, s, 4'h0} + {5'h0, f};
    endfunction

    task automatic check(input string req, input logic [20:0] exp_a, input logic exp_w);
        n_chk++;
        if (phys_addr !== exp_a || wrap_flag !== exp_w) begin
            n_bad++;
            $display("FAIL %s addr=%h wrap=%b expected addr=%h wrap=%b",
                     req, phys_addr, wrap_flag, exp_a, exp_w);
        end
    endtask

    // Checks the current inputs against the model.
    task automatic check_model(input string req);
        logic [20:0] r;
        r = raw_sum(mseg[pick(acc_kind, ovr_sel)], offset);
        if (a20_en) check(req, r, 1'b0);
        else        check(req, {1'b0, r[19:0]}, r[20]);
    endtask

    // One cycle: drive after the falling edge, check, then let the edge write.
    task automatic cycle(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                         input logic [1:0] k, input logic [2:0] o,
                         input logic [15:0] f, input logic a, input string req);
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd;
        acc_kind = k; ovr_sel = o; offset = f; a20_en = a;
        #1 check_model(req);
        @(posedge clk);
        if (we && rst_n) mseg[ws] = wd;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mseg[i] = '0;
        // R8: writes during reset are ignored.
        repeat (2) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'hBEEF;
        end
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++)
            cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'(4 + s), 16'h0012, 1'b1, "R8");
        // R7: load each base, then read it through its override.
        cycle(1'b1, 2'd0, 16'h1000, 2'd0, 3'd0, 16'h0, 1'b1, "R7");
        cycle(1'b1, 2'd1, 16'h2000, 2'd0, 3'd4, 16'h0, 1'b1, "R7");
        cycle(1'b1, 2'd2, 16'h3000, 2'd0, 3'd5, 16'h0, 1'b1, "R7");
        cycle(1'b1, 2'd3, 16'h4000, 2'd0, 3'd6, 16'h0, 1'b1, "R7");
        cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'd7, 16'h0, 1'b1, "R7");
        // R2: default base per access kind.
        for (int k = 0; k < 4; k++)
            cycle(1'b0, 2'd0, 16'h0, 2'(k), 3'd0, 16'h0034, 1'b1, "R2");
        // R3: override codes below 4 mean none, 4..7 win.
        for (int o = 0; o < 8; o++)
            cycle(1'b0, 2'd0, 16'h0, 2'd1, 3'(o), 16'h0056, 1'b1, "R3");
        // R6: top corner with the gate open and closed.
        cycle(1'b1, 2'd3, 16'hFFFF, 2'd0, 3'd0, 16'h0, 1'b1, "R6");
        cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'd0, 16'hFFFF, 1'b1, "R6");
        n_chk++;
        if (phys_addr !== 21'h10FFEF) begin
            n_bad++;
            $display("FAIL R6 addr=%h expected addr=%h", phys_addr, 21'h10FFEF);
        end
        cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'd0, 16'hFFFF, 1'b0, "R6");
        n_chk++;
        if (phys_addr !== 21'h00FFEF || wrap_flag !== 1'b1) begin
            n_bad++;
            $display("FAIL R6 closed addr=%h wrap=%b expected addr=%h wrap=1",
                     phys_addr, wrap_flag, 21'h00FFEF);
        end
        // R4 R5: just below and at the carry point with the gate closed.
        cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'd0, 16'h000F, 1'b0, "R5");
        cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'd0, 16'h0010, 1'b0, "R4");
        // R1: same-cycle response to offset changes with fixed bases.
        cycle(1'b0, 2'd0, 16'h0, 2'd2, 3'd0, 16'h1234, 1'b1, "R1");
        cycle(1'b0, 2'd0, 16'h0, 2'd2, 3'd0, 16'hFEDC, 1'b1, "R1");
        // Random traffic, seeded.
        void'($urandom(32'h5A6E));
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] f;
            logic a;
            f = 16'($urandom);
            if (n % 7 == 0) f = 16'hFFF0 | 16'($urandom % 16);
            a = 1'($urandom);
            cycle(1'($urandom % 3 == 0), 2'($urandom), 16'($urandom),
                  2'($urandom), 3'($urandom), f, a, a ? "R1" : "R4 R5");
        end
        // R8: reset clears previously loaded bases.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 4; i++) mseg[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++)
            cycle(1'b0, 2'd0, 16'h0, 2'd0, 3'(4 + s), 16'h0001, 1'b1, "R8");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule